// File: doc/BRIEF.md
# Colour Lookup Table Loader and Translator

The block takes a palette image delivered as a stream of 32-bit words, learns the pixel depth from a code carried in the first word, and stores the 12-bit RGB colours in an internal table. Once the palette is in place, the block translates a stream of frame pixels into RGB444. In 8 bits per pixel the pixel byte selects a table entry. In 16 bits per pixel the pixel is reduced straight to RGB444 and the table is not used.

A two-bit load-mode input decides what the block consumes after it is enabled. It can take only a palette, only frame pixels, or a palette and then the frame. When the last palette word has been taken, a loaded flag is raised. That flag drives an interrupt line through an enable input. In palette-only mode a clear strobe can drop the flag. In the other modes the flag stays up until the block is disabled.

Top module: `clut_palette_unit`

## Requirements
- R1: In the first palette word after enable, bits 14:12 hold the depth code. Code 3 selects 8 bits per pixel, with a 129-word palette and a 256-entry table. Any other code selects 16 bits per pixel, with a 9-word palette and 16 entries.
- R2: Palette word k is unpacked low halfword first. Bits 11:0 go to entry 2k and bits 27:16 go to entry 2k+1. Halfword bits 15:12 are not stored, and entries at or beyond the table size are discarded.
- R3: In 8 bits per pixel, an accepted pixel's bits 7:0 index the table. The entry appears on outRgb with outValid high one cycle after acceptance.
- R4: In 16 bits per pixel, an accepted pixel p gives outRgb = {p[15:12], p[10:7], p[4:1]} one cycle later, whatever the table holds.
- R5: loadMode encoding: 1 = palette only, 2 = frame only, 0 = palette then frame, 3 = nothing is consumed. Pixels are accepted only while enable is high.
- R6: In mode 0, pixels presented before the palette is complete are dropped and produce no outValid.
- R7: In mode 1 pixels are ignored. In mode 2 palette words leave the table and depth unchanged.
- R8: paletteLoaded rises the cycle after the last palette word is accepted. Further words are ignored until enable goes low and high again. After reset all outputs are 0.
- R9: paletteIrq is high exactly when paletteLoaded and irqEn are both high.
- R10: statusClear drops paletteLoaded only in mode 1. Enable low drops paletteLoaded in every mode and restarts the palette load.
- R11: Table contents and the selected depth survive enable going low. A later frame-only run uses them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low aborts a load and drops the loaded flag |
| loadMode | input | 2 | Consumption mode (see R5) |
| irqEn | input | 1 | Interrupt enable for the loaded flag |
| statusClear | input | 1 | Clear strobe for the loaded flag |
| wordValid | input | 1 | Palette word strobe |
| wordData | input | 32 | Palette word |
| pixValid | input | 1 | Frame pixel strobe |
| pixData | input | 16 | Frame pixel |
| outValid | output | 1 | Translated pixel valid |
| outRgb | output | 12 | Translated pixel, RGB444 |
| paletteLoaded | output | 1 | Palette fully received |
| paletteIrq | output | 1 | Loaded flag gated by irqEn |

## Verification
A word counter or depth register that has drifted shows at the ports in one of two ways. paletteLoaded can rise too early or too late against the word count the depth code implies, and the per-clock comparison catches that on the cycle of the error. A table entry written to the wrong place, or a halfword swapped, stays hidden until a pixel indexes that entry. For that reason the frames sweep indices 0, 1 and 255 and a spread of mid values. A wrong depth or gating decision is visible one cycle after the first affected pixel, as a wrong outValid or outRgb.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam logic [1:0] MODE_BOTH  = 2'd0;
  localparam logic [1:0] MODE_PAL   = 2'd1;
  localparam logic [1:0] MODE_FRAME = 2'd2;
  localparam logic [2:0] CODE_WIDE  = 3'd3;

  typedef struct packed {
    logic palWr;
    logic hdrWord;
    logic pixGo;
  } clutStrobe_t;
endpackage

// File: rtl/clut_ctrl.sv
module clut_ctrl
  import clut_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int SMALL_N = 16,
  parameter int CNT_W   = $clog2((2**IDX_W)/2 + 2)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [1:0]       loadMode,
  input  logic             irqEn,
  input  logic             statusClear,
  input  logic             wordValid,
  input  logic [2:0]       hdrCode,
  input  logic             pixValid,
  output clutStrobe_t      strobe,
  output logic [CNT_W-1:0] wordIdx,
  output logic             loaded,
  output logic             irq
);
  localparam int BIG_WORDS   = (2**IDX_W)/2 + 1;
  localparam int SMALL_WORDS = SMALL_N/2 + 1;

  logic [CNT_W-1:0] cnt, limit, curLimit;
  logic done, palMode, busy, palAcc, lastWord, hdrWide;

  assign palMode  = (loadMode == MODE_PAL) || (loadMode == MODE_BOTH);
  assign busy     = enable && palMode && !done;
  assign palAcc   = wordValid && busy;
  assign hdrWide  = (hdrCode == CODE_WIDE);
  assign curLimit = (cnt == '0) ? (hdrWide ? CNT_W'(BIG_WORDS) : CNT_W'(SMALL_WORDS)) : limit;
  assign lastWord = palAcc && (cnt == curLimit - 1'b1);

  assign strobe.palWr   = palAcc;
  assign strobe.hdrWord = palAcc && (cnt == '0);
  assign strobe.pixGo   = pixValid && enable &&
                          ((loadMode == MODE_FRAME) || ((loadMode == MODE_BOTH) && done));
  assign wordIdx = cnt;
  assign irq     = loaded && irqEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      limit  <= '0;
      done   <= 1'b0;
      loaded <= 1'b0;
    end else if (!enable) begin
      cnt    <= '0;
      done   <= 1'b0;
      loaded <= 1'b0;
    end else begin
      if (palAcc) begin
        cnt <= cnt + 1'b1;
        if (cnt == '0) limit <= curLimit;
      end
      if (lastWord) begin
        done   <= 1'b1;
        loaded <= 1'b1;
      end else if (statusClear && (loadMode == MODE_PAL)) begin
        loaded <= 1'b0;
      end
    end
  end

  // R8
  loaded_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loaded) |-> $past(wordValid) && $past(enable));
  // R10
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !loaded);
  // R7
  pal_only_no_pix_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadMode == MODE_PAL) |-> !strobe.pixGo);
  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0) |-> (cnt <= limit));
endmodule

// File: rtl/clut_datapath.sv
module clut_datapath
  import clut_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int SMALL_N = 16,
  parameter int CNT_W   = $clog2((2**IDX_W)/2 + 2)
)(
  input  logic             clk,
  input  logic             rstN,
  input  clutStrobe_t      strobe,
  input  logic [CNT_W-1:0] wordIdx,
  input  logic [31:0]      wordData,
  input  logic [15:0]      pixData,
  output logic             outValid,
  output logic [11:0]      outRgb
);
  localparam int TABLE_N = 2**IDX_W;
  localparam int ENT_W   = CNT_W + 1;

  logic [11:0] lut [TABLE_N];
  logic        depthWide, wideNow;
  logic [ENT_W-1:0] entLo, entHi, tableSize;
  logic unusedBits;

  assign unusedBits = ^{wordData[31:28], wordData[15]};
  assign wideNow   = strobe.hdrWord ? (wordData[14:12] == CODE_WIDE) : depthWide;
  assign entLo     = {wordIdx, 1'b0};
  assign entHi     = entLo + 1'b1;
  assign tableSize = wideNow ? ENT_W'(TABLE_N) : ENT_W'(SMALL_N);

  always_ff @(posedge clk) begin
    if (strobe.palWr) begin
      if (entLo < tableSize) lut[entLo[IDX_W-1:0]] <= wordData[11:0];
      if (entHi < tableSize) lut[entHi[IDX_W-1:0]] <= wordData[27:16];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                depthWide <= 1'b0;
    else if (strobe.hdrWord)  depthWide <= wideNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outRgb   <= '0;
    end else begin
      outValid <= strobe.pixGo;
      if (strobe.pixGo)
        outRgb <= depthWide ? lut[pixData[IDX_W-1:0]]
                            : {pixData[15:12], pixData[10:7], pixData[4:1]};
    end
  end

  // R3
  pix_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pixGo |=> outValid);
  // R6
  no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pixGo |=> !outValid);
  // R11
  depth_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.hdrWord |=> $stable(depthWide));
endmodule

// File: rtl/clut_palette_unit.sv
module clut_palette_unit
  import clut_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int SMALL_N = 16
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic [1:0]  loadMode,
  input  logic        irqEn,
  input  logic        statusClear,
  input  logic        wordValid,
  input  logic [31:0] wordData,
  input  logic        pixValid,
  input  logic [15:0] pixData,
  output logic        outValid,
  output logic [11:0] outRgb,
  output logic        paletteLoaded,
  output logic        paletteIrq
);
  localparam int CNT_W = $clog2((2**IDX_W)/2 + 2);

  clutStrobe_t      strobe;
  logic [CNT_W-1:0] wordIdx;

  clut_ctrl #(.IDX_W(IDX_W), .SMALL_N(SMALL_N), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .loadMode(loadMode),
    .irqEn(irqEn), .statusClear(statusClear), .wordValid(wordValid),
    .hdrCode(wordData[14:12]), .pixValid(pixValid), .strobe(strobe),
    .wordIdx(wordIdx), .loaded(paletteLoaded), .irq(paletteIrq)
  );

  clut_datapath #(.IDX_W(IDX_W), .SMALL_N(SMALL_N), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIdx(wordIdx),
    .wordData(wordData), .pixData(pixData), .outValid(outValid), .outRgb(outRgb)
  );
endmodule

// File: tb/clut_palette_unit_tb.sv
module clut_palette_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, irqEn = 1'b0, statusClear = 1'b0;
  logic [1:0] loadMode = 2'd0;
  logic wordValid = 1'b0, pixValid = 1'b0;
  logic [31:0] wordData = '0;
  logic [15:0] pixData = '0;
  logic outValid, paletteLoaded, paletteIrq;
  logic [11:0] outRgb;

  always #10 clk = ~clk;

  clut_palette_unit dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .loadMode(loadMode), .irqEn(irqEn),
    .statusClear(statusClear), .wordValid(wordValid), .wordData(wordData),
    .pixValid(pixValid), .pixData(pixData), .outValid(outValid), .outRgb(outRgb),
    .paletteLoaded(paletteLoaded), .paletteIrq(paletteIrq)
  );

  int compared = 0, mismatched = 0, cycles = 0;
  bit finished = 0;
  string curReq = "R8 reset state";

  // behavioural reference
  int tbl [256];
  int mCnt = 0, mTotal = 9;
  bit mDone = 0, mWide = 0, eLoaded = 0, eValid = 0;
  logic [11:0] eRgb = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mDone = 0; mWide = 0; eLoaded = 0; eValid = 0; eRgb = '0;
    end else begin
      bit go;
      go = pixValid && enable && (loadMode == 2 || (loadMode == 0 && mDone));
      eValid = go;
      if (go) eRgb = mWide ? 12'(tbl[pixData[7:0]]) : {pixData[15:12], pixData[10:7], pixData[4:1]};
      if (!enable) begin
        mCnt = 0; mDone = 0; eLoaded = 0;
      end else begin
        if (statusClear && loadMode == 1) eLoaded = 0;
        if (wordValid && loadMode <= 1 && !mDone) begin
          if (mCnt == 0) begin
            mWide = (wordData[14:12] == 3'd3);
            mTotal = mWide ? 129 : 9;
          end
          for (int h = 0; h < 2; h++) begin
            int e;
            e = 2 * mCnt + h;
            if (e < (mWide ? 256 : 16)) tbl[e] = h ? int'(wordData[27:16]) : int'(wordData[11:0]);
          end
          mCnt++;
          if (mCnt == mTotal) begin mDone = 1; eLoaded = 1; end
        end
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s (%s) at cycle %0d: actual %0h expected %0h", curReq, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN && !finished) begin
      cmp("R8 loaded", int'(paletteLoaded), int'(eLoaded));
      cmp("R9 irq", int'(paletteIrq), int'(eLoaded && irqEn));
      cmp("R5 valid", int'(outValid), int'(eValid));
      if (eValid) cmp(mWide ? "R3 lookup" : "R4 bypass", int'(outRgb), int'(eRgb));
    end
  end

  function automatic logic [11:0] hv(int e, int seed);
    return 12'((e * 37 + seed * 11 + 5) & 32'hFFF);
  endfunction

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      step(); wordValid = 0; pixValid = 0; statusClear = 0;
    end
  endtask

  task automatic sendPalette(logic [2:0] code, int nWords, int seed);
    for (int k = 0; k < nWords; k++) begin
      step();
      pixValid = 0; wordValid = 1;
      wordData[31:16] = {4'h5, hv(2 * k + 1, seed)};
      wordData[15:0]  = (k == 0) ? {1'b0, code, hv(0, seed)} : {4'hF, hv(2 * k, seed)};
    end
    step(); wordValid = 0;
  endtask

  task automatic sendPixels(int n, int seed);
    for (int i = 0; i < n; i++) begin
      step();
      wordValid = 0; pixValid = 1;
      case (i)
        0: pixData = 16'hAB00;
        1: pixData = 16'h3401;
        2: pixData = 16'hFFFF;
        default: pixData = 16'((i * 7919 + seed * 131) & 32'hFFFF);
      endcase
    end
    step(); pixValid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2 rstN = 1;
    idle(2);
    // R6: mode 0, pixels before palette are dropped
    curReq = "R6 early pixels"; loadMode = 2'd0; irqEn = 1; enable = 1;
    sendPixels(6, 1);
    // R1 R2: 8-bit depth load, extra words beyond table discarded
    curReq = "R1 R2 wide load"; sendPalette(3'd3, 129, 1);
    idle(2);
    curReq = "R8 extra word ignored"; sendPalette(3'd4, 3, 9);
    // R3: lookup after load in mode 0
    curReq = "R3 lookup"; sendPixels(60, 2);
    // R10: clear ignored outside mode 1
    curReq = "R10 clear ignored"; step(); statusClear = 1; idle(3);
    curReq = "R10 disable"; enable = 0; irqEn = 0; idle(3);
    // R7: palette-only, pixels ignored; narrow load
    curReq = "R7 pal only"; loadMode = 2'd1; enable = 1; irqEn = 1;
    sendPixels(4, 3);
    sendPalette(3'd4, 9, 4);
    sendPixels(4, 5);
    curReq = "R10 clear in mode 1"; step(); statusClear = 1; idle(3);
    enable = 0; idle(2);
    // R4 R7: frame only, bypass, palette words ignored
    curReq = "R4 R7 frame only"; loadMode = 2'd2; enable = 1;
    sendPalette(3'd3, 5, 6);
    sendPixels(30, 7);
    enable = 0; idle(2);
    // R11: wide table retained across disable
    curReq = "R11 retain"; loadMode = 2'd1; enable = 1; sendPalette(3'd3, 129, 8);
    idle(2); enable = 0; idle(2);
    loadMode = 2'd2; enable = 1; sendPixels(50, 9);
    enable = 0; idle(2);
    // R1: unknown code selects narrow depth
    curReq = "R1 other code"; loadMode = 2'd1; enable = 1; sendPalette(3'd5, 9, 10);
    idle(3); enable = 0; idle(1);
    curReq = "R4 after other code"; loadMode = 2'd2; enable = 1; sendPixels(20, 11);
    // R5: mode 3 consumes nothing
    enable = 0; idle(1);
    curReq = "R5 mode 3"; loadMode = 2'd3; enable = 1;
    sendPalette(3'd3, 4, 12); sendPixels(4, 12);
    idle(3);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule